// File: doc/BRIEF.md
# DMA Element Mover with Descriptor Reload

This block is the data-moving core of a multi-channel DMA controller. An arbiter hands it one channel at a time together with that channel's source address, destination address, next-descriptor pointer and control word. The engine then moves exactly one element through a single memory-master port. It reads beats of the source width until a destination-width word is gathered, or it splits one wide read into several narrow writes. Afterwards it hands back the advanced addresses and the decremented count.

When the count of a channel runs out, the engine either follows the descriptor chain or tells the channel to switch itself off. To follow the chain it reads four words from memory and reloads the channel. It also raises a per-channel terminal-count pulse for the interrupt logic whenever the control word that is left in place asks for one. An element whose width codes are out of range is refused with a per-channel error pulse. In every case the arbiter gets a one-cycle done pulse when the work is finished.

Top module: `dma_elem_engine`

## Requirements
- R1: A width code of 0, 1 or 2 selects 1, 2 or 4 bytes; the source code is control[20:18] and the destination code is control[23:21]. If either code is above 2, the engine makes no memory access and no writeback, and pulses err_set[chan] together with done.
- R2: The source is read in beats of the source width until at least the destination width has been gathered, always with at least one beat. With control[26] set, the source address steps up by the source width after each beat; otherwise every beat uses the same address.
- R3: The gathered bytes are written in beats of the destination width until the larger of the two widths has been written. The first byte read is the lowest byte of the first write, data sits in the low byte lanes little-endian, and unused upper lanes are zero. With control[27] set, the destination address steps up by the destination width after each write beat.
- R4: After an element, the writeback carries the stepped addresses and a control word whose count field control[11:0] is one lower, with control[31:12] unchanged.
- R5: If the count becomes zero and the descriptor pointer is nonzero, the engine reads four 32-bit words at pointer+0, +4, +8 and +12, in that order. These give the new source, the new destination, the next pointer and the new control word, and they are written back in place of the stepped values.
- R6: If the count becomes zero and the descriptor pointer is zero, the writeback raises wb_disable.
- R7: tc_set[chan] pulses with the writeback only when the count has reached zero and bit 31 of the control word being written back (after any reload) is set.
- R8: While a memory request waits for mem_ack, the request, direction, address, size and write data stay unchanged.
- R9: done pulses for one cycle at the end of every granted job, and busy is low the next cycle. A go that arrives while busy is ignored.
- R10: A grant whose count field is zero makes no memory access, no writeback and no error, and only pulses done.
- R11: After reset, busy, mem_req, done, wb_valid, tc_set and err_set are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | Grant: start a job for go_chan |
| go_chan | input | CH_W | Granted channel number |
| go_src | input | ADDR_W | Channel source address |
| go_dst | input | ADDR_W | Channel destination address |
| go_lli | input | ADDR_W | Channel next-descriptor pointer |
| go_ctrl | input | 32 | Channel control word |
| busy | output | 1 | A job is in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Access byte address |
| mem_wdata | output | 32 | Write data, low lanes used |
| mem_size | output | 3 | Access size in bytes (1, 2 or 4) |
| mem_ack | input | 1 | Access completed this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| wb_valid | output | 1 | Channel registers to be written back |
| wb_chan | output | CH_W | Channel of the writeback |
| wb_src | output | ADDR_W | New source address |
| wb_dst | output | ADDR_W | New destination address |
| wb_lli | output | ADDR_W | New descriptor pointer |
| wb_ctrl | output | 32 | New control word |
| wb_disable | output | 1 | Clear the channel enable |
| tc_set | output | NCHAN | Terminal-count set pulse per channel |
| err_set | output | NCHAN | Error set pulse per channel |
| done | output | 1 | Job finished |

## Verification
The terminal-count pulse, the register writeback, the channel-disable flag and done are all issued in the same cycle when a count runs out. The bench provokes this both with a null pointer and with a descriptor chain. In the chained case the bit that decides the pulse comes from the reloaded word and not from the old one. The scoreboard compares the pulse and flags against a model that applies the reload before looking at bit 31, in the one cycle where wb_valid is high. A second grant is also pulsed while a job is running, to show that the start of one job cannot overlap the end of another.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;
   localparam int WORD_W = 32;
   localparam int WORD_BYTES = WORD_W / 8;
   localparam int SRC_CODE_LSB = 18;
   localparam int DST_CODE_LSB = 21;
   localparam int SRC_INC_BIT = 26;
   localparam int DST_INC_BIT = 27;
   localparam int TC_BIT = 31;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD,
      ST_WR,
      ST_DESC,
      ST_FIN,
      ST_ABORT
   } eng_state_e;
endpackage

// File: rtl/dma_width_dec.sv
module dma_width_dec #(
   parameter int MAX_CODE = 2,
   parameter int OFF_W = 3
) (
   input  logic [2:0]       code,
   output logic [OFF_W-1:0] bytes,
   output logic             legal
);
   always_comb begin
      legal = (int'(code) <= MAX_CODE);
      bytes = legal ? (OFF_W'(1) << code) : OFF_W'(1);
   end
endmodule

// File: rtl/dma_pack_buf.sv
module dma_pack_buf #(
   parameter int NB = 4,
   parameter int OFF_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic [OFF_W-1:0] ld_off,
   input  logic [OFF_W-1:0] ld_size,
   input  logic [8*NB-1:0]  ld_data,
   input  logic [OFF_W-1:0] rd_off,
   input  logic [OFF_W-1:0] rd_size,
   output logic [8*NB-1:0]  rd_data
);
   logic [8*NB-1:0] store_q;
   logic [8*NB-1:0] ld_shift;
   logic [8*NB-1:0] rd_shift;

   assign ld_shift = ld_data << (8 * ld_off);
   assign rd_shift = store_q >> (8 * rd_off);

   for (genvar g = 0; g < NB; g++) begin : g_lane
      localparam logic [OFF_W:0] LANE = (OFF_W + 1)'(g);
      logic hit;
      assign hit = ld && ({1'b0, ld_off} <= LANE) &&
                   (LANE < ({1'b0, ld_off} + {1'b0, ld_size}));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            store_q[8*g +: 8] <= '0;
         end else if (hit) begin
            store_q[8*g +: 8] <= ld_shift[8*g +: 8];
         end
      end
      assign rd_data[8*g +: 8] = (LANE < {1'b0, rd_size}) ? rd_shift[8*g +: 8] : 8'h00;
   end
endmodule

// File: rtl/dma_elem_engine.sv
module dma_elem_engine
   import dma_eng_pkg::*;
#(
   parameter int NCHAN = 8,
   parameter int ADDR_W = 32,
   parameter int CNT_W = 12,
   localparam int CH_W = (NCHAN > 1) ? $clog2(NCHAN) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [CH_W-1:0]   go_chan,
   input  logic [ADDR_W-1:0] go_src,
   input  logic [ADDR_W-1:0] go_dst,
   input  logic [ADDR_W-1:0] go_lli,
   input  logic [31:0]       go_ctrl,
   output logic              busy,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   output logic [2:0]        mem_size,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata,
   output logic              wb_valid,
   output logic [CH_W-1:0]   wb_chan,
   output logic [ADDR_W-1:0] wb_src,
   output logic [ADDR_W-1:0] wb_dst,
   output logic [ADDR_W-1:0] wb_lli,
   output logic [31:0]       wb_ctrl,
   output logic              wb_disable,
   output logic [NCHAN-1:0]  tc_set,
   output logic [NCHAN-1:0]  err_set,
   output logic              done
);
   localparam int NB = WORD_BYTES;
   localparam int OFF_W = $clog2(NB) + 1;
   localparam int MAX_CODE = $clog2(NB);

   if (NCHAN < 1 || NCHAN > 32) begin : g_bad_nchan
      $error("dma_elem_engine: NCHAN must be 1..32");
   end
   if (ADDR_W < 8 || ADDR_W > WORD_W) begin : g_bad_addr
      $error("dma_elem_engine: ADDR_W must be 8..32");
   end
   if (CNT_W < 1 || CNT_W > SRC_CODE_LSB) begin : g_bad_cnt
      $error("dma_elem_engine: CNT_W must not reach the width fields");
   end
   if (OFF_W != 3) begin : g_bad_off
      $error("dma_elem_engine: size port assumes 32-bit words");
   end

   eng_state_e        state_q;
   logic [CH_W-1:0]   ch_q;
   logic [ADDR_W-1:0] src_q, dst_q, lli_q, lli_nxt_q;
   logic [31:0]       ctrl_q;
   logic [OFF_W-1:0]  sw_q, dw_q, off_q;
   logic [1:0]        didx_q;
   logic              dis_q, bad_q, last_q;

   // width decode of the incoming control word (source and destination)
   logic [OFF_W-1:0] dec_bytes [2];
   logic [1:0]       dec_legal;
   for (genvar k = 0; k < 2; k++) begin : g_wdec
      localparam int LSB = (k == 0) ? SRC_CODE_LSB : DST_CODE_LSB;
      dma_width_dec #(.MAX_CODE(MAX_CODE), .OFF_W(OFF_W)) u_dec (
         .code  (go_ctrl[LSB +: 3]),
         .bytes (dec_bytes[k]),
         .legal (dec_legal[k])
      );
   end

   logic [OFF_W-1:0] xmax;
   logic [OFF_W-1:0] rd_nxt, wr_nxt;
   logic             beat_ack;
   logic [31:0]      pk_data;
   logic             cnt_one;

   assign xmax     = (sw_q > dw_q) ? sw_q : dw_q;
   assign rd_nxt   = off_q + sw_q;
   assign wr_nxt   = off_q + dw_q;
   assign beat_ack = mem_req && mem_ack;
   assign cnt_one  = (ctrl_q[CNT_W-1:0] == CNT_W'(1));

   dma_pack_buf #(.NB(NB), .OFF_W(OFF_W)) u_pack (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld      (state_q == ST_RD && mem_ack),
      .ld_off  (off_q),
      .ld_size (sw_q),
      .ld_data (mem_rdata),
      .rd_off  (off_q),
      .rd_size (dw_q),
      .rd_data (pk_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         ch_q      <= '0;
         src_q     <= '0;
         dst_q     <= '0;
         lli_q     <= '0;
         lli_nxt_q <= '0;
         ctrl_q    <= '0;
         sw_q      <= OFF_W'(1);
         dw_q      <= OFF_W'(1);
         off_q     <= '0;
         didx_q    <= '0;
         dis_q     <= 1'b0;
         bad_q     <= 1'b0;
         last_q    <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (go) begin
                  ch_q   <= go_chan;
                  src_q  <= go_src;
                  dst_q  <= go_dst;
                  lli_q  <= go_lli;
                  ctrl_q <= go_ctrl;
                  sw_q   <= dec_bytes[0];
                  dw_q   <= dec_bytes[1];
                  off_q  <= '0;
                  didx_q <= '0;
                  dis_q  <= 1'b0;
                  last_q <= 1'b0;
                  bad_q  <= !(&dec_legal);
                  if (!(&dec_legal) || go_ctrl[CNT_W-1:0] == '0) begin
                     state_q <= ST_ABORT;
                  end else begin
                     state_q <= ST_RD;
                  end
               end
            end
            ST_RD: begin
               if (beat_ack) begin
                  if (ctrl_q[SRC_INC_BIT]) src_q <= src_q + ADDR_W'(sw_q);
                  if (rd_nxt >= dw_q) begin
                     off_q   <= '0;
                     state_q <= ST_WR;
                  end else begin
                     off_q <= rd_nxt;
                  end
               end
            end
            ST_WR: begin
               if (beat_ack) begin
                  if (ctrl_q[DST_INC_BIT]) dst_q <= dst_q + ADDR_W'(dw_q);
                  if (wr_nxt >= xmax) begin
                     off_q <= '0;
                     ctrl_q[CNT_W-1:0] <= ctrl_q[CNT_W-1:0] - CNT_W'(1);
                     last_q <= cnt_one;
                     if (cnt_one && lli_q != '0) begin
                        state_q <= ST_DESC;
                     end else begin
                        dis_q   <= cnt_one;
                        state_q <= ST_FIN;
                     end
                  end else begin
                     off_q <= wr_nxt;
                  end
               end
            end
            ST_DESC: begin
               if (beat_ack) begin
                  didx_q <= didx_q + 2'd1;
                  unique case (didx_q)
                     2'd0: src_q <= mem_rdata[ADDR_W-1:0];
                     2'd1: dst_q <= mem_rdata[ADDR_W-1:0];
                     2'd2: lli_nxt_q <= mem_rdata[ADDR_W-1:0];
                     default: begin
                        ctrl_q  <= mem_rdata;
                        lli_q   <= lli_nxt_q;
                        state_q <= ST_FIN;
                     end
                  endcase
               end
            end
            ST_FIN, ST_ABORT: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = src_q;
      mem_size  = sw_q;
      mem_wdata = '0;
      unique case (state_q)
         ST_RD: mem_req = 1'b1;
         ST_WR: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = dst_q;
            mem_size  = dw_q;
            mem_wdata = pk_data;
         end
         ST_DESC: begin
            mem_req  = 1'b1;
            mem_addr = lli_q + ADDR_W'({didx_q, 2'b00});
            mem_size = 3'd4;
         end
         default: ;
      endcase
   end

   assign busy       = (state_q != ST_IDLE);
   assign wb_valid   = (state_q == ST_FIN);
   assign done       = (state_q == ST_FIN) || (state_q == ST_ABORT);
   assign wb_chan    = ch_q;
   assign wb_src     = src_q;
   assign wb_dst     = dst_q;
   assign wb_lli     = lli_q;
   assign wb_ctrl    = ctrl_q;
   assign wb_disable = wb_valid && dis_q;

   for (genvar c = 0; c < NCHAN; c++) begin : g_chan_pulse
      assign tc_set[c]  = wb_valid && last_q && ctrl_q[TC_BIT] && (ch_q == CH_W'(c));
      assign err_set[c] = (state_q == ST_ABORT) && bad_q && (ch_q == CH_W'(c));
   end
endmodule

// File: rtl/dma_elem_engine_chk.sv
module dma_elem_engine_chk #(
   parameter int NCHAN = 8,
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              go,
   input logic              busy,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [31:0]       mem_wdata,
   input logic [2:0]        mem_size,
   input logic              mem_ack,
   input logic              wb_valid,
   input logic              wb_disable,
   input logic [NCHAN-1:0]  tc_set,
   input logic [NCHAN-1:0]  err_set,
   input logic              done
);
   // R8
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                              && $stable(mem_size) && $stable(mem_wdata));
   // R1
   size_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_size == 3'd1 || mem_size == 3'd2 || mem_size == 3'd4));
   // R7
   tc_with_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_set != '0) |-> wb_valid && done && $onehot0(tc_set));
   // R1
   err_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_set != '0) |-> done && !wb_valid && !mem_req && $onehot0(err_set));
   // R6
   disable_with_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_disable |-> wb_valid && done);
   // R9
   done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);
   // R9
   go_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go && !busy |=> busy);
   // R9
   done_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_req);
endmodule

bind dma_elem_engine dma_elem_engine_chk #(.NCHAN(NCHAN), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dma_elem_engine_bench.sv
module dma_elem_engine_bench;
   localparam int NCH = 8;
   localparam int CHW = 3;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n;
   logic go = 1'b0;
   logic [CHW-1:0] go_chan = '0;
   logic [31:0] go_src = '0, go_dst = '0, go_lli = '0, go_ctrl = '0;
   logic busy, mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic [2:0] mem_size;
   logic mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic wb_valid, wb_disable, done;
   logic [CHW-1:0] wb_chan;
   logic [31:0] wb_src, wb_dst, wb_lli, wb_ctrl;
   logic [NCH-1:0] tc_set, err_set;

   dma_elem_engine #(.NCHAN(NCH), .ADDR_W(32), .CNT_W(12)) u_dma_elem_engine (.*);

   typedef struct {
      logic [31:0] addr; logic [2:0] size; logic we; logic [31:0] data; logic desc;
   } acc_t;
   typedef struct {
      int ch; logic [31:0] src, dst, lli, ctrl; logic dis; logic tc;
   } wb_t;

   acc_t acc_q[$];
   wb_t  wb_q[$];
   logic [7:0] mem [256];
   int n_tests = 0, n_fail = 0;
   int n_acc = 0, n_wb = 0, n_err = 0, n_done = 0;
   int lat = 0, wcnt = 0;
   logic [31:0] hold_addr;
   logic [NCH-1:0] last_err = '0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] rd32(input logic [31:0] a);
      logic [31:0] w;
      for (int b = 0; b < 4; b++) w[8*b +: 8] = mem[(a + b) & 32'hFF];
      return w;
   endfunction

   // memory responder and access scoreboard
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_ack = 1'b0; wcnt = 0;
      end else if (mem_ack) begin
         mem_ack = 1'b0; wcnt = 0;
      end else if (mem_req) begin
         if (wcnt > 0) chk(mem_addr == hold_addr, "R8", "held address", mem_addr, hold_addr);
         hold_addr = mem_addr;
         if (wcnt >= lat) begin
            acc_t e;
            n_acc++;
            mem_ack = 1'b1;
            if (acc_q.size() == 0) begin
               chk(1'b0, "R9", "unexpected access", mem_addr, 32'h0);
            end else begin
               e = acc_q.pop_front();
               chk(mem_addr == e.addr, e.desc ? "R5" : (e.we ? "R3" : "R2"), "address", mem_addr, e.addr);
               chk(mem_size == e.size, "R1", "size", {29'd0, mem_size}, {29'd0, e.size});
               chk(mem_we == e.we, e.we ? "R3" : "R2", "direction", {31'd0, mem_we}, {31'd0, e.we});
               if (e.we) chk(mem_wdata == e.data, "R3", "write data", mem_wdata, e.data);
            end
            if (mem_we) begin
               for (int b = 0; b < 4; b++)
                  if (b < int'(mem_size)) mem[(mem_addr + b) & 32'hFF] = mem_wdata[8*b +: 8];
            end else begin
               mem_rdata = '0;
               for (int b = 0; b < 4; b++)
                  if (b < int'(mem_size)) mem_rdata[8*b +: 8] = mem[(mem_addr + b) & 32'hFF];
            end
         end else begin
            wcnt++;
         end
      end
   end

   // writeback and pulse monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (done) n_done++;
         if (err_set != '0) begin n_err++; last_err = err_set; end
         if (wb_valid) begin
            wb_t w;
            n_wb++;
            if (wb_q.size() == 0) begin
               chk(1'b0, "R9", "unexpected writeback", {29'd0, wb_chan}, 32'h0);
            end else begin
               w = wb_q.pop_front();
               chk(int'(wb_chan) == w.ch, "R9", "writeback channel", {29'd0, wb_chan}, w.ch);
               chk(wb_src == w.src, "R4", "source writeback", wb_src, w.src);
               chk(wb_dst == w.dst, "R4", "destination writeback", wb_dst, w.dst);
               chk(wb_lli == w.lli, "R5", "pointer writeback", wb_lli, w.lli);
               chk(wb_ctrl == w.ctrl, "R4", "control writeback", wb_ctrl, w.ctrl);
               chk(wb_disable == w.dis, "R6", "disable flag", {31'd0, wb_disable}, {31'd0, w.dis});
               chk(tc_set == (w.tc ? NCH'(1) << w.ch : '0), "R7", "terminal count",
                   {24'd0, tc_set}, w.tc ? (32'd1 << w.ch) : 32'd0);
               chk(done, "R9", "done with writeback", {31'd0, done}, 32'd1);
            end
         end
      end
   end

   // reference model: pushes expected accesses and writeback
   task automatic model(input int ch, input logic [31:0] src, dst, lli, ctrl,
                        output logic [31:0] ns, nd, nl, nc);
      int sw, dw, xm, n, cnt;
      logic [7:0] buff [8];
      logic [31:0] s, d, data;
      wb_t w;
      ns = src; nd = dst; nl = lli; nc = ctrl;
      if (ctrl[20:18] > 3'd2 || ctrl[23:21] > 3'd2 || ctrl[11:0] == 12'd0) return;
      sw = 1 << ctrl[20:18]; dw = 1 << ctrl[23:21];
      xm = (sw > dw) ? sw : dw;
      s = src; n = 0;
      do begin
         acc_q.push_back('{s, 3'(sw), 1'b0, 32'h0, 1'b0});
         for (int b = 0; b < sw; b++) buff[n + b] = mem[(s + b) & 32'hFF];
         if (ctrl[26]) s = s + sw;
         n += sw;
      end while (n < dw);
      d = dst; n = 0;
      do begin
         data = '0;
         for (int b = 0; b < dw; b++) data[8*b +: 8] = buff[n + b];
         acc_q.push_back('{d, 3'(dw), 1'b1, data, 1'b0});
         if (ctrl[27]) d = d + dw;
         n += dw;
      end while (n < xm);
      cnt = int'(ctrl[11:0]) - 1;
      w.ch = ch; w.src = s; w.dst = d; w.lli = lli;
      w.ctrl = {ctrl[31:12], 12'(cnt)}; w.dis = 1'b0;
      if (cnt == 0) begin
         if (lli != 0) begin
            for (int i = 0; i < 4; i++) acc_q.push_back('{lli + 4*i, 3'd4, 1'b0, 32'h0, 1'b1});
            w.src = rd32(lli); w.dst = rd32(lli + 4);
            w.lli = rd32(lli + 8); w.ctrl = rd32(lli + 12);
         end else begin
            w.dis = 1'b1;
         end
      end
      w.tc = (cnt == 0) && w.ctrl[31];
      wb_q.push_back(w);
      ns = w.src; nd = w.dst; nl = w.lli; nc = w.ctrl;
   endtask

   task automatic run(input int ch, input logic [31:0] src, dst, lli, ctrl,
                      output logic [31:0] ns, nd, nl, nc);
      int d0;
      model(ch, src, dst, lli, ctrl, ns, nd, nl, nc);
      @(negedge clk);
      while (busy) @(negedge clk);
      d0 = n_done;
      go = 1'b1; go_chan = CHW'(ch); go_src = src; go_dst = dst; go_lli = lli; go_ctrl = ctrl;
      @(negedge clk);
      go = 1'b0;
      while (n_done == d0) @(negedge clk);
      @(negedge clk);
      chk(acc_q.size() == 0, "R2", "expected accesses left", acc_q.size(), 0);
      chk(wb_q.size() == 0, "R4", "expected writebacks left", wb_q.size(), 0);
      chk(!busy, "R9", "busy after done", {31'd0, busy}, 32'd0);
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL R9 watchdog expired: actual hung expected done");
      finish_run();
   end

   initial begin
      logic [31:0] a, b, c, e;
      int acc0, wb0, err0;
      for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
      // descriptors at 0x80 (tc requested) and 0x90 (tc not requested)
      for (int i = 0; i < 4; i++) begin
         logic [31:0] w0 [4], w1 [4];
         w0 = '{32'h28, 32'h68, 32'h90, 32'h8C48_0005};
         w1 = '{32'h2C, 32'h6C, 32'h0, 32'h0C48_0003};
         for (int k = 0; k < 4; k++) begin
            mem[8'h80 + 4*i + k] = w0[i][8*k +: 8];
            mem[8'h90 + 4*i + k] = w1[i][8*k +: 8];
         end
      end
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(!busy && !mem_req && !done, "R11", "busy/req/done in reset", {29'd0, busy, mem_req, done}, 0);
      chk(!wb_valid && tc_set == '0 && err_set == '0, "R11", "wb/tc/err in reset",
          {15'd0, wb_valid, tc_set, err_set}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // word to word, two elements, second ends the channel (R4, R6, R7)
      lat = 1;
      run(3, 32'h10, 32'h40, 32'h0, 32'h8C48_0002, a, b, c, e);
      run(3, a, b, c, e, a, b, c, e);
      // packing bytes into a word (R2)
      lat = 0;
      run(0, 32'h20, 32'h50, 32'h0, 32'h0C40_0001, a, b, c, e);
      // splitting a word into bytes (R3)
      run(1, 32'h24, 32'h58, 32'h0, 32'h8C08_0001, a, b, c, e);
      // no increments: repeated addresses (R2, R3)
      lat = 2;
      run(2, 32'h30, 32'h60, 32'h0, 32'h0020_0003, a, b, c, e);
      // reload from chain with tc from new word (R5, R7)
      lat = 1;
      run(5, 32'h34, 32'h70, 32'h80, 32'h0C24_0001, a, b, c, e);
      // reload whose new word clears tc although old word sets it (R7)
      run(6, 32'h38, 32'h74, 32'h90, 32'h8C24_0001, a, b, c, e);

      // illegal destination width code 3 (R1)
      acc0 = n_acc; wb0 = n_wb; err0 = n_err;
      run(4, 32'h10, 32'h40, 32'h0, 32'h0C60_0001, a, b, c, e);
      chk(n_acc == acc0, "R1", "accesses on bad width", n_acc - acc0, 0);
      chk(n_wb == wb0, "R1", "writeback on bad width", n_wb - wb0, 0);
      chk(n_err == err0 + 1 && last_err == NCH'(1) << 4, "R1", "error pulse", {24'd0, last_err}, 32'h10);

      // zero count grant (R10)
      acc0 = n_acc; wb0 = n_wb; err0 = n_err;
      run(7, 32'h10, 32'h40, 32'h0, 32'h0C48_0000, a, b, c, e);
      chk(n_acc == acc0 && n_wb == wb0, "R10", "activity on zero count", n_acc - acc0 + n_wb - wb0, 0);
      chk(n_err == err0, "R10", "error on zero count", n_err - err0, 0);

      // go while busy is ignored (R9)
      lat = 2;
      wb0 = n_wb;
      model(4, 32'h14, 32'h44, 32'h0, 32'h0C48_0005, a, b, c, e);
      @(negedge clk);
      go = 1'b1; go_chan = 3'd4; go_src = 32'h14; go_dst = 32'h44; go_lli = 32'h0; go_ctrl = 32'h0C48_0005;
      @(negedge clk);
      go = 1'b0;
      @(negedge clk);
      go = 1'b1; go_chan = 3'd6; go_src = 32'h18; go_dst = 32'h48; go_ctrl = 32'h0C60_0001;
      @(negedge clk);
      go = 1'b0;
      repeat (40) @(negedge clk);
      chk(n_wb == wb0 + 1, "R9", "writebacks after busy go", n_wb - wb0, 1);
      chk(acc_q.size() == 0 && wb_q.size() == 0, "R9", "scoreboard drained", acc_q.size() + wb_q.size(), 0);
      chk(!busy, "R9", "idle at end", {31'd0, busy}, 0);
      finish_run();
   end
endmodule